// File: doc/BRIEF.md
# Ethernet MAC Transmit Frame Engine

This block turns a byte stream from a transmit FIFO into a 4-bit media-independent transmit stream. It adds a preamble and a start-of-frame delimiter, pads short frames with zero bytes, can append the frame check sequence, and sends one nibble per clock. A new frame starts only when the control inputs allow it and when enough bytes wait in the FIFO. This gives a header checksum unit upstream time to finish before its field goes out.

Until 64 bytes of the frame have been sent, the engine keeps each data byte it takes from the FIFO in a small retain store. A collision in that window stops the attempt with a jam and a retry pulse. The next attempt replays the kept bytes, then carries on from the FIFO. Deciding when the medium is free and reporting collisions are done outside the block, as are deferral, backoff and the host side. Each attempt ends with one of three pulses: done, abort or retry.

Top module: `mac_tx_engine`

## Requirements
- R1: A new frame starts only in a cycle where `tx_enable` is 1, `tx_halt` is 0 and `medium_free` is 1. With `tx_halt` at 1 or `tx_enable` at 0, `mii_tx_en` stays 0 and the FIFO is not read.
- R2: A new frame starts only when `fifo_level` is nonzero and at least `preload_bytes`. A smaller level keeps the engine idle however long it waits.
- R3: Every attempt opens with 16 nibbles on `mii_txd`: fifteen of value 0x5, then 0xD. Assembled low nibble first, these are the bytes 0x55 seven times and then 0xD5.
- R4: Data bytes follow in FIFO order at one nibble per clock. Each byte sends its low nibble first. The byte that carries `fifo_last` is the final data byte.
- R5: A frame with fewer than 60 data bytes is extended with 0x00 bytes to exactly 60 bytes. A frame of 60 bytes or more gets no padding.
- R6: When `crc_append` is 1 at frame start, four check bytes follow the data and pad. They form the CRC-32 of those bytes (polynomial 0x04C11DB7, register preset to all ones, input reflected, result inverted) and are sent least significant byte first.
- R7: When `crc_append` is 0 at frame start, the frame ends directly after the last data or pad byte.
- R8: In the first cycle after the last nibble of a good frame, `mii_tx_en` is 0 and `done_pulse` is 1 for exactly one cycle. `done_pulse`, `abort_pulse` and `retry_pulse` are never high together.
- R9: If a byte taken from the FIFO carries `fifo_err`, that byte is not sent. The engine drives one cycle with `mii_tx_en` and `mii_tx_er` both 1, then raises `abort_pulse` and not `done_pulse`.
- R10: If `collision` is 1 while the preamble or the first 64 bytes of the frame are being sent, the engine sends 8 jam nibbles and raises `retry_pulse`. It then restarts without waiting for preload or halt, and sends the same complete frame, using retained bytes first.
- R11: If `collision` is 1 after 64 bytes of the frame have been sent, it is ignored and the frame completes unchanged.
- R12: `fifo_pop` is never 1 while `fifo_level` is 0. If the FIFO is empty when a new data byte is needed, the frame ends with the R9 abort sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit function enabled |
| tx_halt | input | 1 | Request to start no further frames |
| crc_append | input | 1 | Append check bytes to the next frame |
| medium_free | input | 1 | Medium may be taken now |
| collision | input | 1 | Collision seen on the medium |
| preload_bytes | input | LVLW | Bytes that must wait in the FIFO before a start |
| fifo_level | input | LVLW | Bytes now held in the FIFO |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_last | input | 1 | Head byte ends the frame |
| fifo_err | input | 1 | Head byte carries an upstream error |
| fifo_pop | output | 1 | Take the head byte this cycle |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_tx_er | output | 1 | Transmit error |
| done_pulse | output | 1 | Frame completed |
| abort_pulse | output | 1 | Frame aborted |
| retry_pulse | output | 1 | Attempt ended by collision |

## Verification
Some rules are checked on every cycle. An error nibble always has enable set. The three status pulses never overlap. Completion always follows directly on the end of a burst. Every burst opens with a preamble nibble and follows a cycle with `tx_enable` high. The FIFO is never read while empty. Other behaviour shows only in the bench scenarios: the frame contents, padding, check bytes, the preload and halt waits, replay after a collision that gives a byte-identical frame, and late collisions being ignored. For these, each burst is rebuilt into bytes and compared against a frame computed independently.

// File: rtl/mac_tx_pkg.sv
package mac_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_JAM,
        ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic       err;
        logic       last;
        logic [7:0] data;
    } tx_byte_t;

    localparam int        PRE_NIBS  = 16;
    localparam logic [3:0] PRE_NIB  = 4'h5;
    localparam logic [3:0] SFD_HI   = 4'hD;
    localparam logic [3:0] JAM_NIB  = 4'hF;
    localparam logic [31:0] CRC_RPOLY = 32'hEDB88320;

    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] d);
        logic [31:0] c;
        c = crc ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_RPOLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/mac_tx_crc32.sv
module mac_tx_crc32
    import mac_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end
endmodule

// File: rtl/mac_tx_retain_buf.sv
module mac_tx_retain_buf
    import mac_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  tx_byte_t      wdata,
    input  logic [AW-1:0] raddr,
    output tx_byte_t      rdata
);
    tx_byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mac_tx_nibble_mux.sv
module mac_tx_nibble_mux
    import mac_tx_pkg::*;
(
    input  tx_state_e   state,
    input  logic [3:0]  cnt,
    input  logic        ph,
    input  logic [7:0]  cur,
    input  logic [31:0] fcs,
    output logic [3:0]  txd,
    output logic        tx_en,
    output logic        tx_er
);
    logic [31:0] fcs_sh;
    assign fcs_sh = fcs >> {cnt[2:0], 2'b00};

    always_comb begin
        txd   = 4'h0;
        tx_en = 1'b1;
        tx_er = 1'b0;
        unique case (state)
            ST_PRE:   txd = (int'(cnt) == PRE_NIBS - 1) ? SFD_HI : PRE_NIB;
            ST_DATA,
            ST_PAD:   txd = ph ? cur[7:4] : cur[3:0];
            ST_FCS:   txd = fcs_sh[3:0];
            ST_JAM:   txd = JAM_NIB;
            ST_ABORT: tx_er = 1'b1;
            default:  tx_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/mac_tx_engine.sv
module mac_tx_engine
    import mac_tx_pkg::*;
#(
    parameter int LVLW   = 8,
    parameter int RETAIN = 64,
    parameter int MINLEN = 60,
    parameter int CNTW   = 11,
    parameter int JAMN   = 8
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_enable,
    input  logic            tx_halt,
    input  logic            crc_append,
    input  logic            medium_free,
    input  logic            collision,
    input  logic [LVLW-1:0] preload_bytes,
    input  logic [LVLW-1:0] fifo_level,
    input  logic [7:0]      fifo_data,
    input  logic            fifo_last,
    input  logic            fifo_err,
    output logic            fifo_pop,
    output logic [3:0]      mii_txd,
    output logic            mii_tx_en,
    output logic            mii_tx_er,
    output logic            done_pulse,
    output logic            abort_pulse,
    output logic            retry_pulse
);
    localparam int AW = $clog2(RETAIN);
    localparam int SW = $clog2(RETAIN + 1);
    localparam logic [CNTW-1:0] CMAX = '1;

    tx_state_e       state_q;
    logic [3:0]      cnt_q;
    logic            ph_q;
    tx_byte_t        cur_q;
    logic [CNTW-1:0] didx_q;
    logic [SW-1:0]   sent_q;
    logic [SW-1:0]   kept_q;
    logic            retry_q;
    logic            crc_en_q;

    logic            in_tx, window_open, col_hit, start;
    logic            fetch_req, from_buf, underrun, load_data, buf_we;
    logic            byte_done, tail_req, pad_more, pad_load;
    logic [CNTW-1:0] fetch_idx, didx_nxt;
    logic [SW-1:0]   sent_nxt;
    tx_byte_t        buf_rd, fetched;
    logic [31:0]     crc_q;

    assign in_tx       = (state_q == ST_PRE) || (state_q == ST_DATA) ||
                         (state_q == ST_PAD) || (state_q == ST_FCS);
    assign window_open = int'(sent_q) < RETAIN;
    assign col_hit     = collision && in_tx && window_open;
    assign start       = (state_q == ST_IDLE) && tx_enable && medium_free &&
                         (retry_q || (!tx_halt && fifo_level != '0 &&
                                      fifo_level >= preload_bytes));

    assign didx_nxt  = (didx_q == CMAX) ? didx_q : didx_q + 1'b1;
    assign sent_nxt  = (int'(sent_q) == RETAIN) ? sent_q : sent_q + 1'b1;
    assign fetch_req = !col_hit &&
                       (((state_q == ST_PRE) && int'(cnt_q) == PRE_NIBS - 1) ||
                        ((state_q == ST_DATA) && ph_q && !cur_q.last));
    assign fetch_idx = (state_q == ST_PRE) ? '0 : didx_nxt;
    assign from_buf  = int'(fetch_idx) < int'(kept_q);
    assign fetched   = from_buf ? buf_rd : tx_byte_t'{err: fifo_err, last: fifo_last, data: fifo_data};
    assign underrun  = fetch_req && !from_buf && (fifo_level == '0);
    assign fifo_pop  = fetch_req && !from_buf && (fifo_level != '0);
    assign buf_we    = fifo_pop && int'(fetch_idx) < RETAIN;
    assign load_data = fetch_req && !underrun && !fetched.err;

    assign byte_done = ph_q && ((state_q == ST_DATA) || (state_q == ST_PAD));
    assign tail_req  = !col_hit && byte_done && ((state_q == ST_PAD) || cur_q.last);
    assign pad_more  = int'(didx_q) + 1 < MINLEN;
    assign pad_load  = tail_req && pad_more;

    mac_tx_retain_buf #(.DEPTH(RETAIN)) u_keep (
        .clk   (clk),
        .we    (buf_we),
        .waddr (fetch_idx[AW-1:0]),
        .wdata (fetched),
        .raddr (fetch_idx[AW-1:0]),
        .rdata (buf_rd)
    );

    mac_tx_crc32 u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (start),
        .upd   (load_data || pad_load),
        .din   (pad_load ? 8'h00 : fetched.data),
        .crc_q (crc_q)
    );

    mac_tx_nibble_mux u_mux (
        .state (state_q),
        .cnt   (cnt_q),
        .ph    (ph_q),
        .cur   (cur_q.data),
        .fcs   (~crc_q),
        .txd   (mii_txd),
        .tx_en (mii_tx_en),
        .tx_er (mii_tx_er)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            ph_q        <= 1'b0;
            cur_q       <= '0;
            didx_q      <= '0;
            sent_q      <= '0;
            kept_q      <= '0;
            retry_q     <= 1'b0;
            crc_en_q    <= 1'b0;
            done_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
            retry_pulse <= 1'b0;
        end else begin
            done_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
            retry_pulse <= 1'b0;
            if (buf_we) begin
                kept_q <= SW'(int'(fetch_idx) + 1);
            end
            if (col_hit) begin
                state_q <= ST_JAM;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            state_q <= ST_PRE;
                            cnt_q   <= '0;
                            ph_q    <= 1'b0;
                            sent_q  <= '0;
                            didx_q  <= '0;
                            if (!retry_q) begin
                                kept_q   <= '0;
                                crc_en_q <= crc_append;
                            end
                        end
                    end
                    ST_PRE: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (fetch_req) begin
                            if (load_data) begin
                                state_q <= ST_DATA;
                                cur_q   <= fetched;
                                didx_q  <= '0;
                                ph_q    <= 1'b0;
                            end else begin
                                state_q <= ST_ABORT;
                            end
                        end
                    end
                    ST_DATA, ST_PAD: begin
                        ph_q <= !ph_q;
                        if (ph_q) begin
                            sent_q <= sent_nxt;
                        end
                        if (fetch_req) begin
                            if (load_data) begin
                                cur_q  <= fetched;
                                didx_q <= didx_nxt;
                            end else begin
                                state_q <= ST_ABORT;
                            end
                        end else if (tail_req) begin
                            if (pad_more) begin
                                state_q <= ST_PAD;
                                cur_q   <= '0;
                                didx_q  <= didx_nxt;
                            end else if (crc_en_q) begin
                                state_q <= ST_FCS;
                                cnt_q   <= '0;
                            end else begin
                                state_q    <= ST_IDLE;
                                done_pulse <= 1'b1;
                                retry_q    <= 1'b0;
                            end
                        end
                    end
                    ST_FCS: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q[0]) begin
                            sent_q <= sent_nxt;
                        end
                        if (cnt_q == 4'd7) begin
                            state_q    <= ST_IDLE;
                            done_pulse <= 1'b1;
                            retry_q    <= 1'b0;
                        end
                    end
                    ST_JAM: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (int'(cnt_q) == JAMN - 1) begin
                            state_q     <= ST_IDLE;
                            retry_q     <= 1'b1;
                            retry_pulse <= 1'b1;
                        end
                    end
                    default: begin
                        state_q     <= ST_IDLE;
                        abort_pulse <= 1'b1;
                        retry_q     <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mac_tx_engine_chk.sv
module mac_tx_engine_chk #(
    parameter int LVLW = 8
)(
    input logic            clk,
    input logic            rst,
    input logic            tx_enable,
    input logic [LVLW-1:0] fifo_level,
    input logic            fifo_pop,
    input logic [3:0]      mii_txd,
    input logic            mii_tx_en,
    input logic            mii_tx_er,
    input logic            done_pulse,
    input logic            abort_pulse,
    input logic            retry_pulse
);
    AST_ER_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        mii_tx_er |-> mii_tx_en); // R9

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_pulse, abort_pulse, retry_pulse})); // R8

    AST_DONE_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (!mii_tx_en && $past(mii_tx_en))); // R8

    AST_START_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(mii_tx_en) |-> $past(tx_enable)); // R1

    AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(mii_tx_en) |-> (mii_txd == 4'h5)); // R3

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (fifo_level != '0)); // R12

    AST_RETRY_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        retry_pulse |-> (!mii_tx_en && $past(mii_tx_en) && !$past(mii_tx_er))); // R10
endmodule

bind mac_tx_engine mac_tx_engine_chk #(.LVLW(LVLW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_enable   (tx_enable),
    .fifo_level  (fifo_level),
    .fifo_pop    (fifo_pop),
    .mii_txd     (mii_txd),
    .mii_tx_en   (mii_tx_en),
    .mii_tx_er   (mii_tx_er),
    .done_pulse  (done_pulse),
    .abort_pulse (abort_pulse),
    .retry_pulse (retry_pulse)
);

// File: tb/mac_tx_engine_tb.sv
`timescale 1ns/1ps
module mac_tx_engine_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_enable = 1'b1, tx_halt = 1'b0, crc_append = 1'b1;
    logic       medium_free = 1'b1, collision = 1'b0;
    logic [7:0] preload_bytes = 8'd1, fifo_level = 8'd0, fifo_data = 8'd0;
    logic       fifo_last = 1'b0, fifo_err = 1'b0, fifo_pop;
    logic [3:0] mii_txd;
    logic       mii_tx_en, mii_tx_er, done_pulse, abort_pulse, retry_pulse;

    always #2.5 clk = ~clk;

    mac_tx_engine u_dut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .tx_halt(tx_halt),
        .crc_append(crc_append), .medium_free(medium_free), .collision(collision),
        .preload_bytes(preload_bytes), .fifo_level(fifo_level), .fifo_data(fifo_data),
        .fifo_last(fifo_last), .fifo_err(fifo_err), .fifo_pop(fifo_pop),
        .mii_txd(mii_txd), .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er),
        .done_pulse(done_pulse), .abort_pulse(abort_pulse), .retry_pulse(retry_pulse)
    );

    int checks = 0, errors = 0;
    int n_done = 0, n_abort = 0, n_retry = 0, n_er = 0, skip = 0;
    bit any_tx = 0, in_burst = 0, saw_er = 0;
    logic [9:0] fq [$];
    logic [9:0] pend [$];
    logic [7:0] exp_b [$];
    int         exp_len [$];
    logic [3:0] nibs [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // FIFO model: pops on the design's request, registered view of head and level.
    always @(posedge clk) begin
        if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
        fifo_level <= 8'(fq.size());
        fifo_data  <= (fq.size() > 0) ? fq[0][7:0] : 8'h00;
        fifo_last  <= (fq.size() > 0) ? fq[0][8] : 1'b0;
        fifo_err   <= (fq.size() > 0) ? fq[0][9] : 1'b0;
    end

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [31:0] rev32(input logic [31:0] v);
        for (int i = 0; i < 32; i++) rev32[i] = v[31-i];
    endfunction

    // Driver: stages frame bytes and pushes the expected wire bytes to the scoreboard.
    task automatic build_frame(input int n, input bit fcs, input int seed);
        logic [7:0]  body [$];
        logic [31:0] c;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'(seed + i * 13);
            body.push_back(d);
            pend.push_back({1'b0, (i == n - 1), d});
        end
        while (body.size() < 60) body.push_back(8'h00); // R5
        for (int i = 0; i < 7; i++) exp_b.push_back(8'h55); // R3
        exp_b.push_back(8'hD5);
        foreach (body[i]) exp_b.push_back(body[i]); // R4
        c = 32'hFFFF_FFFF;
        foreach (body[i]) begin
            c = c ^ {rev8(body[i]), 24'h0};
            for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        c = ~rev32(c);
        if (fcs) for (int k = 0; k < 4; k++) exp_b.push_back(c[8*k +: 8]); // R6
        exp_len.push_back(8 + body.size() + (fcs ? 4 : 0));
    endtask

    task automatic push_n(input int k);
        for (int i = 0; i < k && pend.size() > 0; i++) fq.push_back(pend.pop_front());
    endtask

    task automatic finish_burst();
        int len;
        bit ok;
        if (saw_er) begin
            n_er++;
        end else if (skip > 0) begin
            skip--;
        end else if (exp_len.size() == 0) begin
            chk(0, "R4", "unexpected burst, nibbles", nibs.size(), 0);
        end else begin
            len = exp_len.pop_front();
            chk(nibs.size() == 2 * len, "R5/R6/R7", "frame length in bytes", nibs.size() / 2, len);
            ok = 1;
            for (int i = 0; i < len; i++) begin
                logic [7:0] e = exp_b.pop_front();
                logic [7:0] a = (2 * i + 1 < nibs.size()) ? {nibs[2*i+1], nibs[2*i]} : 8'hxx;
                if (ok && a !== e) begin
                    ok = 0;
                    chk(0, "R3/R4/R5/R6", $sformatf("byte %0d", i), a, e);
                end
            end
            if (ok) chk(1, "R4", "frame content", 0, 0);
        end
        nibs.delete();
        saw_er = 0;
    endtask

    // Monitor: samples on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (mii_tx_en) begin
                nibs.push_back(mii_txd);
                any_tx = 1;
                in_burst = 1;
                if (mii_tx_er) saw_er = 1;
            end else if (in_burst) begin
                in_burst = 0;
                finish_burst();
            end
            if (done_pulse) n_done++;
            if (abort_pulse) n_abort++;
            if (retry_pulse) n_retry++;
        end
    end

    task automatic wait_end();
        int t = 0;
        @(negedge clk);
        while (!(done_pulse || abort_pulse) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_rise();
        while (!mii_tx_en) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R8", "watchdog expired, cycles", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d0, a0, r0;
        repeat (4) @(negedge clk);
        chk(mii_tx_en == 0 && mii_tx_er == 0, "R8", "tx idle during reset", mii_tx_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({done_pulse, abort_pulse, retry_pulse, fifo_pop} == 0, "R8", "status after reset",
            {done_pulse, abort_pulse, retry_pulse, fifo_pop}, 0);

        // Short frame with check bytes: pad and CRC.
        d0 = n_done;
        build_frame(20, 1, 3); crc_append = 1; push_n(20); wait_end();
        chk(n_done == d0 + 1, "R8", "done pulses", n_done - d0, 1);

        // Long frame without check bytes.
        crc_append = 0; build_frame(64, 0, 7); push_n(64); wait_end();
        // Short frame without check bytes: padding only.
        build_frame(12, 0, 91); push_n(12); wait_end(); // R7
        crc_append = 1;

        // Halt holds a new frame back.
        tx_halt = 1; any_tx = 0;
        build_frame(16, 1, 40); push_n(16);
        repeat (80) @(negedge clk);
        chk(any_tx == 0, "R1", "transmit while halted", any_tx, 0);
        tx_halt = 0; wait_end();

        // Disabled transmitter stays silent.
        tx_enable = 0; any_tx = 0;
        build_frame(61, 1, 5); push_n(61);
        repeat (80) @(negedge clk);
        chk(any_tx == 0, "R1", "transmit while disabled", any_tx, 0);
        tx_enable = 1; wait_end();

        // Preload threshold.
        preload_bytes = 8'd20; any_tx = 0;
        build_frame(25, 1, 77); push_n(10);
        repeat (80) @(negedge clk);
        chk(any_tx == 0, "R2", "start below preload", any_tx, 0);
        push_n(15); wait_end();
        chk(any_tx == 1, "R2", "start at preload", any_tx, 1);
        preload_bytes = 8'd1;

        // Upstream error.
        d0 = n_done; a0 = n_abort; r0 = n_er;
        for (int i = 0; i < 6; i++) fq.push_back({(i == 5), (i == 5), 8'(i + 1)});
        wait_end();
        chk(n_abort == a0 + 1, "R9", "abort pulses", n_abort - a0, 1);
        chk(n_er == r0 + 1, "R9", "bursts with tx_er", n_er - r0, 1);
        chk(n_done == d0, "R9", "done pulses on error", n_done - d0, 0);

        // Underrun: data ends without a last marker.
        a0 = n_abort;
        for (int i = 0; i < 5; i++) fq.push_back({2'b00, 8'(i + 9)});
        wait_end();
        chk(n_abort == a0 + 1, "R12", "abort on underrun", n_abort - a0, 1);

        // Early collision: jam, retry, identical replay.
        d0 = n_done; r0 = n_retry; skip = 1;
        build_frame(30, 1, 17); push_n(30);
        wait_rise();
        repeat (40) @(negedge clk);
        collision = 1; @(negedge clk); collision = 0;
        wait_end();
        chk(n_retry == r0 + 1, "R10", "retry pulses", n_retry - r0, 1);
        chk(n_done == d0 + 1, "R10", "replayed frame done", n_done - d0, 1);
        chk(skip == 0, "R10", "aborted attempt seen on wire", skip, 0);

        // Late collision is ignored.
        r0 = n_retry;
        build_frame(80, 1, 200); push_n(80);
        wait_rise();
        repeat (16 + 2 * 70) @(negedge clk);
        collision = 1; @(negedge clk); collision = 0;
        wait_end();
        chk(n_retry == r0, "R11", "retry after late collision", n_retry - r0, 0);

        repeat (5) @(negedge clk);
        chk(exp_len.size() == 0, "R4", "frames left unmatched", exp_len.size(), 0);
        chk(fq.size() == 0, "R12", "bytes left in FIFO", fq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule